// File: doc/BRIEF.md
# Three-Channel Interval Timer with Waveform Output

This block holds three independent 16-bit counters behind a small word-addressed register bus made of an address, write data, a write enable, a read enable and combinational read data. Each counter either runs across its full range and wraps, or restarts whenever it reaches a programmed interval. It can count up or down. A power-of-two prescaler can slow it, and it can be clocked from the system clock or from one edge of an external clock input.

A compare value per channel drives a waveform pin. The pin switches to its active level when the counter reaches the compare value and returns to idle when the counter restarts. The interval therefore sets the PWM period and the compare value sets the duty. The polarity is selectable and the output has an active-low enable. Software halts a channel, programs its clock, interval and compare registers, and then writes the counter-control register with the restart bit set and the halt bit clear. Each channel also has a readable current count and a sticky status register that clears when it is read.

Top module: `tri_timer`

## Requirements
- R1: After reset every count reads 0, every status reads 0, every clock-control register reads 0, every counter-control register reads 0x21 (halt bit 0 and wave-off bit 5 set), and every wave output is 0.
- R2: The word address is channel*8 + register index. The indices are 0 clock control, 1 counter control, 2 interval, 3 compare, 4 count (read only) and 5 status (read only). Writable registers read back what was written, except that the restart bit (counter control bit 4) reads 0. Unused indices and channel 3 read 0, and writes to them change nothing.
- R3: In interval mode (counter control bit 1 = 1), an up counter goes 0..interval and then returns to 0. A down counter (bit 2 = 1) goes interval..0 and then returns to interval.
- R4: In wrap mode (bit 1 = 0), an up counter passes through 0xFFFF to 0 and a down counter passes through 0 to 0xFFFF.
- R5: With the prescale enable (clock control bit 0) clear, the counter steps on every source clock. With it set and the exponent field (bits 4:1) equal to N, the counter steps once every 2^(N+1) source clocks.
- R6: With source select (clock control bit 5) set, the counter steps on synchronised edges of the external clock: rising edges when bit 6 = 0 and falling edges when bit 6 = 1.
- R7: While halt (counter control bit 0) is set, the count holds its value.
- R8: Writing the restart bit loads 0 (or the interval when counting down) and restarts the prescaler on the following clock. This happens even while the channel is halted.
- R9: With compare enable (bit 3) set and the wave enable active, the wave output goes to its active level when the count reaches the compare value and returns to idle when the counter restarts. Polarity bit 6 = 1 gives idle low and active high. Bit 6 = 0 gives idle high and active low.
- R10: A compare value of 0, a compare value above the interval, or compare enable clear leaves the wave output at its idle level for the whole period.
- R11: With the wave-off bit (bit 5) set, the wave output is 0 whatever the counter does.
- R12: Status bit 0 (interval restart), bit 1 (compare hit) and bit 2 (wrap) are sticky and clear when the status register is read.
- R13: The channels are independent: activity on one channel does not change another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count source |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | External count clock, synchronised inside |
| regAddr | input | 5 | Word address: channel in bits 4:3, register index in bits 2:0 |
| regWdata | input | 16 | Write data |
| regWe | input | 1 | Write enable, captured on the clock edge |
| regRe | input | 1 | Read strobe; on the status index it clears the flags |
| regRdata | output | 16 | Combinational read data for regAddr |
| waveOut | output | 3 | Per-channel waveform output |

## Verification
On every cycle the assertions check four things: a halted counter holds its value, an undivided up counter in wrap mode advances by exactly one, an up counter in interval mode never passes its interval, and status flags stay set until they are read. They also check that an up restart lands on zero and that no compare flag appears while compare is disabled. The bench scenarios are the only way to show the prescale ratios, the external edge selection, the PWM duty and polarity counted over whole periods, the constant outputs at the compare corner values, and the address decode.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 4;
  localparam int STAT_W = 3;

  // status flag positions
  localparam int ST_INTV = 0;
  localparam int ST_HIT  = 1;
  localparam int ST_WRAP = 2;

  // counter-control bit positions
  localparam int CTL_HALT    = 0;
  localparam int CTL_MODE    = 1;
  localparam int CTL_DOWN    = 2;
  localparam int CTL_CMPEN   = 3;
  localparam int CTL_RESTART = 4;
  localparam int CTL_WAVEOFF = 5;
  localparam int CTL_POL     = 6;

  typedef enum logic [2:0] {
    REG_CLK   = 3'd0,
    REG_CTL   = 3'd1,
    REG_INTV  = 3'd2,
    REG_CMP   = 3'd3,
    REG_COUNT = 3'd4,
    REG_STAT  = 3'd5
  } regSelT;

  typedef struct packed {
    logic [CNT_W-1:0] interval;
    logic [CNT_W-1:0] matchVal;
    logic             wavePol;
    logic             waveEnN;
    logic             matchEn;
    logic             down;
    logic             mode;
    logic             halt;
    logic             extFall;
    logic             srcExt;
    logic [PRE_W-1:0] preExp;
    logic             preEn;
  } chanCfgT;

  typedef struct packed {
    logic restart;
    logic clrStatus;
  } chanStbT;

  localparam chanCfgT CFG_RESET = '{
    interval: '0, matchVal: '0, wavePol: 1'b0, waveEnN: 1'b1,
    matchEn: 1'b0, down: 1'b0, mode: 1'b0, halt: 1'b1,
    extFall: 1'b0, srcExt: 1'b0, preExp: '0, preEn: 1'b0
  };
endpackage

// File: rtl/tri_timer_ctrl.sv
module tri_timer_ctrl
  import tri_timer_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [AW-1:0]                  regAddr,
  input  logic [CNT_W-1:0]               regWdata,
  input  logic                           regWe,
  input  logic                           regRe,
  output logic [CNT_W-1:0]               regRdata,
  output chanCfgT [NCH-1:0]              chanCfg,
  output chanStbT [NCH-1:0]              chanStb,
  input  logic [NCH-1:0][CNT_W-1:0]      chanCount,
  input  logic [NCH-1:0][STAT_W-1:0]     chanStatus
);
  localparam int SEL_W = 3;
  localparam int CH_W  = AW - SEL_W;

  logic [CH_W-1:0]          chSel;
  regSelT                   regSel;
  logic [NCH-1:0][CNT_W-1:0] readVal;

  assign chSel  = regAddr[AW-1:SEL_W];
  assign regSel = regSelT'(regAddr[SEL_W-1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_reg
    logic    hit;
    logic    restartQ;
    chanCfgT cfgQ;

    assign hit = (chSel == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ     <= CFG_RESET;
        restartQ <= 1'b0;
      end else begin
        restartQ <= regWe && hit && (regSel == REG_CTL) && regWdata[CTL_RESTART];
        if (regWe && hit) begin
          case (regSel)
            REG_CLK: begin
              cfgQ.preEn   <= regWdata[0];
              cfgQ.preExp  <= regWdata[PRE_W:1];
              cfgQ.srcExt  <= regWdata[PRE_W+1];
              cfgQ.extFall <= regWdata[PRE_W+2];
            end
            REG_CTL: begin
              cfgQ.halt    <= regWdata[CTL_HALT];
              cfgQ.mode    <= regWdata[CTL_MODE];
              cfgQ.down    <= regWdata[CTL_DOWN];
              cfgQ.matchEn <= regWdata[CTL_CMPEN];
              cfgQ.waveEnN <= regWdata[CTL_WAVEOFF];
              cfgQ.wavePol <= regWdata[CTL_POL];
            end
            REG_INTV: cfgQ.interval <= regWdata;
            REG_CMP:  cfgQ.matchVal <= regWdata;
            default: ;
          endcase
        end
      end
    end

    assign chanCfg[c]           = cfgQ;
    assign chanStb[c].restart   = restartQ;
    assign chanStb[c].clrStatus = regRe && hit && (regSel == REG_STAT);

    always_comb begin
      case (regSel)
        REG_CLK:   readVal[c] = CNT_W'({cfgQ.extFall, cfgQ.srcExt, cfgQ.preExp, cfgQ.preEn});
        REG_CTL:   readVal[c] = CNT_W'({cfgQ.wavePol, cfgQ.waveEnN, 1'b0, cfgQ.matchEn,
                                        cfgQ.down, cfgQ.mode, cfgQ.halt});
        REG_INTV:  readVal[c] = cfgQ.interval;
        REG_CMP:   readVal[c] = cfgQ.matchVal;
        REG_COUNT: readVal[c] = chanCount[c];
        REG_STAT:  readVal[c] = CNT_W'(chanStatus[c]);
        default:   readVal[c] = '0;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chSel == CH_W'(c)) regRdata = readVal[c];
    end
  end
endmodule

// File: rtl/tri_timer_dp.sv
module tri_timer_dp
  import tri_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       extClk,
  input  chanCfgT [NCH-1:0]          chanCfg,
  input  chanStbT [NCH-1:0]          chanStb,
  output logic [NCH-1:0][CNT_W-1:0]  chanCount,
  output logic [NCH-1:0][STAT_W-1:0] chanStatus,
  output logic [NCH-1:0]             waveOut
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W:0]   ONE_W = (CNT_W+1)'(1);

  // two-stage synchroniser plus one stage for edge detection
  logic [2:0] extSh;
  logic       extRiseEv, extFallEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSh <= '0;
    else       extSh <= {extSh[1:0], extClk};
  end

  assign extRiseEv = extSh[1] & ~extSh[2];
  assign extFallEv = ~extSh[1] & extSh[2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chanCfgT            k;
    chanStbT            s;
    logic [CNT_W-1:0]   cntQ, preQ, nextCnt, preLim;
    logic [CNT_W:0]     span;
    logic               srcTick, preDone, tick, atEnd, wrapEv, matchHit, waveQ;
    logic [STAT_W-1:0]  statQ, newFlags;

    assign k = chanCfg[c];
    assign s = chanStb[c];

    always_comb begin
      span    = ONE_W << ({1'b0, k.preExp} + (PRE_W+1)'(1));
      preLim  = CNT_W'(span - ONE_W);
      srcTick = k.srcExt ? (k.extFall ? extFallEv : extRiseEv) : 1'b1;
      preDone = !k.preEn || (preQ == preLim);
      tick    = srcTick && preDone && !k.halt && !s.restart;
      if (k.down)      atEnd = (cntQ == '0);
      else if (k.mode) atEnd = (cntQ == k.interval);
      else             atEnd = (cntQ == '1);
      if (atEnd && k.mode) nextCnt = k.down ? k.interval : '0;
      else                 nextCnt = k.down ? cntQ - ONE : cntQ + ONE;
      wrapEv   = tick && atEnd;
      matchHit = tick && !atEnd && k.matchEn && (nextCnt == k.matchVal);
      newFlags = '0;
      newFlags[ST_INTV] = wrapEv && k.mode;
      newFlags[ST_HIT]  = matchHit;
      newFlags[ST_WRAP] = wrapEv && !k.mode;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ  <= '0;
        preQ  <= '0;
        waveQ <= 1'b0;
        statQ <= '0;
      end else begin
        statQ <= (s.clrStatus ? '0 : statQ) | newFlags;
        if (s.restart) begin
          cntQ  <= k.down ? k.interval : '0;
          preQ  <= '0;
          waveQ <= 1'b0;
        end else begin
          if (srcTick && k.preEn && !k.halt) preQ <= preDone ? '0 : preQ + ONE;
          if (tick) cntQ <= nextCnt;
          if (wrapEv)        waveQ <= 1'b0;
          else if (matchHit) waveQ <= 1'b1;
        end
      end
    end

    assign chanCount[c]  = cntQ;
    assign chanStatus[c] = statQ;
    assign waveOut[c]    = k.waveEnN ? 1'b0 : (k.wavePol ? waveQ : !waveQ);
  end
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic [AW-1:0]    regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic             regWe,
  input  logic             regRe,
  output logic [CNT_W-1:0] regRdata,
  output logic [NCH-1:0]   waveOut
);
  chanCfgT [NCH-1:0]          chanCfg;
  chanStbT [NCH-1:0]          chanStb;
  logic [NCH-1:0][CNT_W-1:0]  chanCount;
  logic [NCH-1:0][STAT_W-1:0] chanStatus;

  tri_timer_ctrl #(.NCH(NCH), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata),
    .chanCfg(chanCfg), .chanStb(chanStb),
    .chanCount(chanCount), .chanStatus(chanStatus)
  );

  tri_timer_dp #(.NCH(NCH)) dp_i (
    .clk(clk), .rstN(rstN), .extClk(extClk),
    .chanCfg(chanCfg), .chanStb(chanStb),
    .chanCount(chanCount), .chanStatus(chanStatus), .waveOut(waveOut)
  );
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
  import tri_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input chanCfgT [NCH-1:0]          cfg,
  input chanStbT [NCH-1:0]          stb,
  input logic [NCH-1:0][CNT_W-1:0]  count,
  input logic [NCH-1:0][STAT_W-1:0] status
);
  logic unusedCfgBits;
  assign unusedCfgBits = ^cfg;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      cfg[c].halt && !stb[c].restart |=> $stable(count[c]));

    p_unit_step_r5: assert property (@(posedge clk) disable iff (!rstN)
      !cfg[c].preEn && !cfg[c].srcExt && !cfg[c].halt && !cfg[c].down &&
      !cfg[c].mode && !stb[c].restart
      |=> count[c] == $past(count[c]) + CNT_W'(1));

    p_interval_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
      cfg[c].mode && !cfg[c].down && (count[c] <= cfg[c].interval)
      |=> count[c] <= $past(cfg[c].interval));

    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].restart && !cfg[c].down |=> count[c] == '0);

    p_no_hit_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
      !cfg[c].matchEn && !status[c][ST_HIT] |=> !status[c][ST_HIT]);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      p_sticky_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
        status[c][b] && !stb[c].clrStatus |=> status[c][b]);
    end
  end
endmodule

bind tri_timer tri_timer_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rstN(rstN), .cfg(chanCfg), .stb(chanStb),
  .count(chanCount), .status(chanStatus)
);

// File: tb/tri_timer_tb_top.sv
`timescale 1ns/1ps
module tri_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClk = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [15:0] regRdata;
  logic [2:0]  waveOut;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tri_timer dut_i (
    .clk(clk), .rstN(rstN), .extClk(extClk), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata), .waveOut(waveOut)
  );

  // register indices and control words
  localparam logic [2:0] I_CLK = 0, I_CTL = 1, I_INTV = 2, I_CMP = 3, I_CNT = 4, I_STAT = 5;
  localparam logic [15:0] HALT = 16'h0021;

  // {clkCfg[8], ctlCfg[8], interval[16], waitCycles[12], req[4], expectedCount[16]}
  localparam logic [63:0] VEC [8] = '{
    {8'h00, 8'h32, 16'd9,   12'd25,  4'd3, 16'd4},
    {8'h00, 8'h30, 16'd0,   12'd30,  4'd4, 16'd29},
    {8'h01, 8'h32, 16'd100, 12'd30,  4'd5, 16'd14},
    {8'h05, 8'h32, 16'd100, 12'd50,  4'd5, 16'd6},
    {8'h00, 8'h36, 16'd7,   12'd20,  4'd3, 16'd4},
    {8'h00, 8'h34, 16'd2,   12'd6,   4'd4, 16'hFFFD},
    {8'h1F, 8'h30, 16'd0,   12'd100, 4'd5, 16'd0},
    {8'h1E, 8'h30, 16'd0,   12'd12,  4'd5, 16'd11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and consume one rising edge
  task automatic wr(input int ch, input logic [2:0] idx, input logic [15:0] d);
    regAddr = {ch[1:0], idx}; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [2:0] idx, output logic [15:0] d);
    regAddr = {ch[1:0], idx}; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [15:0] clkCfg, input logic [15:0] intv,
                       input logic [15:0] cmp, input logic [15:0] ctl);
    wr(ch, I_CTL, HALT);
    wr(ch, I_CLK, clkCfg);
    wr(ch, I_INTV, intv);
    wr(ch, I_CMP, cmp);
    wr(ch, I_CTL, ctl);
  endtask

  task automatic highCount(input int ch, output int n);
    n = 0;
    repeat (100) begin
      @(negedge clk);
      #1 n += int'(waveOut[ch]);
    end
  endtask

  task automatic pwmCase(input string req, input logic [15:0] cmp, input logic [15:0] ctl,
                         input int expHigh);
    int n;
    setup(0, 16'h0, 16'd9, cmp, ctl);
    idle(20);
    highCount(0, n);
    chk(req, n, expHigh);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [15:0] d, a, b;
    int n;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset state
    rd(0, I_CNT, d);  chk("R1 count", d, 16'h0);
    rd(0, I_CTL, d);  chk("R1 ctl", d, 16'h21);
    rd(1, I_CLK, d);  chk("R1 clk", d, 16'h0);
    rd(2, I_STAT, d); chk("R1 status", d, 16'h0);
    chk("R1 wave", waveOut, 3'b000);

    // R2: decode and readback
    wr(2, I_INTV, 16'h1234);
    rd(2, I_INTV, d); chk("R2 interval readback", d, 16'h1234);
    wr(2, I_CTL, 16'h005B);
    rd(2, I_CTL, d);  chk("R2 restart bit reads 0", d, 16'h004B);
    rd(0, 3'd6, d);   chk("R2 unused index", d, 16'h0);
    wr(3, I_INTV, 16'hBEEF);
    rd(3, I_INTV, d); chk("R2 channel 3 reads 0", d, 16'h0);
    rd(2, I_INTV, d); chk("R2 channel 3 write ignored", d, 16'h1234);

    // R3 R4 R5: table of count scenarios on channel 0
    for (int i = 0; i < 8; i++) begin
      logic [63:0] v;
      v = VEC[i];
      setup(0, {8'h0, v[63:56]}, v[47:32], 16'h0, {8'h0, v[55:48]});
      idle(int'(v[31:20]));
      rd(0, I_CNT, d);
      chk($sformatf("R%0d table vector %0d", v[19:16], i), d, v[15:0]);
    end

    // R7: halt holds the count
    setup(0, 16'h0, 16'h0, 16'h0, 16'h0030);
    idle(10);
    wr(0, I_CTL, HALT);
    rd(0, I_CNT, a);  chk("R7 count at halt", a, 16'd10);
    idle(20);
    rd(0, I_CNT, b);  chk("R7 count held", b, a);

    // R8: restart loads interval when counting down, also while halted
    wr(0, I_INTV, 16'd7);
    wr(0, I_CTL, 16'h0036);
    idle(1);
    rd(0, I_CNT, d);  chk("R8 down restart value", d, 16'd7);
    wr(0, I_INTV, 16'h0055);
    wr(0, I_CTL, 16'h0035);
    idle(5);
    rd(0, I_CNT, d);  chk("R8 restart while halted", d, 16'h0055);

    // R13: channel 1 runs, channel 0 stays put
    setup(1, 16'h0, 16'h0, 16'h0, 16'h0030);
    idle(30);
    rd(1, I_CNT, d);  chk("R13 channel 1 count", d, 16'd29);
    rd(0, I_CNT, d);  chk("R13 channel 0 untouched", d, 16'h0055);

    // R6: external clock, rising then falling edges
    setup(1, 16'h0020, 16'h0, 16'h0, 16'h0030);
    repeat (5) begin extClk = 1'b1; idle(4); extClk = 1'b0; idle(4); end
    idle(6);
    rd(1, I_CNT, d);  chk("R6 rising edges", d, 16'd5);
    setup(1, 16'h0060, 16'h0, 16'h0, 16'h0030);
    repeat (5) begin extClk = 1'b1; idle(4); extClk = 1'b0; idle(4); end
    idle(6);
    rd(1, I_CNT, d);  chk("R6 falling edges", d, 16'd5);

    // R9: duty and polarity, interval 9 (period 10)
    pwmCase("R9 cmp3 high active", 16'd3, 16'h005A, 70);
    pwmCase("R9 cmp3 low active", 16'd3, 16'h001A, 30);
    pwmCase("R9 cmp5 high active", 16'd5, 16'h005A, 50);

    // R10: constant output cases
    pwmCase("R10 cmp0", 16'd0, 16'h005A, 0);
    pwmCase("R10 cmp above interval", 16'd12, 16'h005A, 0);
    pwmCase("R10 compare disabled", 16'd3, 16'h0052, 0);
    pwmCase("R10 cmp0 idle high", 16'd0, 16'h001A, 100);

    // R11: wave-off forces 0
    pwmCase("R11 off high polarity", 16'd3, 16'h007A, 0);
    pwmCase("R11 off low polarity", 16'd3, 16'h003A, 0);

    // R12: sticky status, cleared by read
    wr(0, I_CTL, HALT);
    rd(0, I_STAT, d);
    pwmCase("R12 run", 16'd3, 16'h005A, 70);
    wr(0, I_CTL, HALT);
    rd(0, I_STAT, d); chk("R12 interval and hit flags", d, 16'h0003);
    rd(0, I_STAT, d); chk("R12 cleared by read", d, 16'h0);
    wr(2, I_CTL, HALT);
    rd(2, I_STAT, d);
    setup(2, 16'h0, 16'd2, 16'h0, 16'h0034);
    idle(10);
    wr(2, I_CTL, 16'h0025);
    rd(2, I_STAT, d); chk("R12 wrap flag", d, 16'h0004);
    rd(2, I_CNT, d);  chk("R4 down wrap count", d, 16'hFFFE - 16'd6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule